// File: doc/BRIEF.md
# Self-Refresh Sequencer

This block is the part of a DRAM controller that moves the memory into self-refresh and brings it back. A power manager raises an enter request while the controller is idle. The block then issues one refresh command in the same cycle that it drives the clock-enable pin low. It holds the device in that state until the power manager asks for an exit.

On exit, the block keeps clock enable low until the clock source reports a stable clock. It then raises clock enable and drives only NOP commands for a fixed window. That window is the larger of two cycle counts: the one needed to finish any refresh running inside the device, and the one needed for its DLL to relock.

Normal commands from the scheduler pass through only while the block reports ready. At any other time a command request is refused with a busy flag and never reaches the memory.

Top module: `sref_sequencer`

## Requirements
- R1: After reset the block is idle: `cke` is 1, `ready` is 1, `cmdBusy` is 0, and `memCmd` is NOP. Commands on `memCmd` are coded {rasN,casN,weN}: NOP is 3'b111 and refresh is 3'b001.
- R2: While `ready` is 1, `memCmd` equals `hostCmd` in the same cycle when `hostCmdValid` is 1, and NOP otherwise.
- R3: An `enterReq` sampled while idle produces, in the next cycle, exactly one cycle with `cke` 0 and `memCmd` refresh (3'b001). In the cycle before it, `cke` is 1. Refresh appears at no other time.
- R4: During self-refresh, `cke` stays 0, `ready` stays 0, and `memCmd` is NOP, whatever the host command inputs do.
- R5: After `exitReq`, `cke` stays 0 until `clkStable` has been sampled 1. `cke` rises in the cycle after that sample.
- R6: From the cycle `cke` rises, `memCmd` is NOP and `ready` is 0 for exactly NOP_CYC cycles, where NOP_CYC = max(XSNR_CYC, DLL_CYC). `ready` is 1 in the following cycle.
- R7: A host command presented while `ready` is 0 raises `cmdBusy` in that cycle and is never driven onto `memCmd`.
- R8: `exitReq` has no effect while idle, and `enterReq` has no effect while in self-refresh.
- R9: After wake-up the block forwards commands again and accepts a new enter request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enterReq | input | 1 | Power manager asks for self-refresh |
| exitReq | input | 1 | Power manager asks to leave self-refresh |
| clkStable | input | 1 | Memory clock is running and stable |
| hostCmdValid | input | 1 | Scheduler presents a command |
| hostCmd | input | 3 | Scheduler command {rasN,casN,weN} |
| cke | output | 1 | Memory clock enable |
| memCmd | output | 3 | Command to memory {rasN,casN,weN} |
| cmdBusy | output | 1 | Host command refused this cycle |
| ready | output | 1 | Normal commands allowed |

## Verification
The outputs are a combinational function of the registered state and the host inputs. Forwarding and busy therefore respond in the same cycle as the host command. The refresh-with-low-clock-enable cycle follows one edge after the enter request. Clock enable rises one edge after `clkStable` is sampled high, and `ready` follows exactly NOP_CYC edges after that. The bench changes inputs 2 ns after a rising edge and samples 1 ns later, well before the next edge. During the wake-up window it counts the cycles with `ready` low and compares the total with the maximum of the two timing parameters, which it computes itself.

// File: rtl/sref_pkg.sv
package sref_pkg;
  // Command coding {rasN, casN, weN}
  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_REF = 3'b001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTER,
    ST_IN_SR,
    ST_WAIT_CLK,
    ST_NOP_WAIT,
    ST_READY
  } srState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic ckeHigh;
    logic issueRef;
    logic passCmd;
    logic nopCount;
  } srStrobe_t;
endpackage

// File: rtl/sref_ctrl.sv
module sref_ctrl
  import sref_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enterReq,
  input  logic      exitReq,
  input  logic      clkStable,
  input  logic      cntDone,
  output srStrobe_t stb
);
  srState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:     if (enterReq)  nextState = ST_ENTER;
      ST_ENTER:                   nextState = ST_IN_SR;
      ST_IN_SR:    if (exitReq)   nextState = ST_WAIT_CLK;
      ST_WAIT_CLK: if (clkStable) nextState = ST_NOP_WAIT;
      ST_NOP_WAIT: if (cntDone)   nextState = ST_READY;
      ST_READY:                   nextState = ST_IDLE;
      default:                    nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    stb.ckeHigh  = (state == ST_IDLE) || (state == ST_READY) || (state == ST_NOP_WAIT);
    stb.issueRef = (state == ST_ENTER);
    stb.passCmd  = (state == ST_IDLE) || (state == ST_READY);
    stb.nopCount = (state == ST_NOP_WAIT);
  end
endmodule

// File: rtl/sref_dp.sv
module sref_dp
  import sref_pkg::*;
#(
  parameter int NOP_CYC = 200
) (
  input  logic      clk,
  input  logic      rstN,
  input  srStrobe_t stb,
  input  logic      hostCmdValid,
  input  logic [2:0] hostCmd,
  output logic      cntDone,
  output logic      cke,
  output logic [2:0] memCmd,
  output logic      cmdBusy,
  output logic      ready
);
  localparam int CNT_W = $clog2(NOP_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NOP_CYC - 1);

  logic [CNT_W-1:0] nopCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             nopCnt <= '0;
    else if (stb.nopCount) nopCnt <= nopCnt + 1'b1;
    else                   nopCnt <= '0;
  end

  assign cntDone = stb.nopCount && (nopCnt == LAST);

  always_comb begin
    cke     = stb.ckeHigh;
    ready   = stb.passCmd;
    cmdBusy = hostCmdValid && !stb.passCmd;
    if (stb.issueRef)                       memCmd = CMD_REF;
    else if (stb.passCmd && hostCmdValid)   memCmd = hostCmd;
    else                                    memCmd = CMD_NOP;
  end
endmodule

// File: rtl/sref_sequencer.sv
module sref_sequencer
  import sref_pkg::*;
#(
  parameter int XSNR_CYC = 20,
  parameter int DLL_CYC  = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enterReq,
  input  logic       exitReq,
  input  logic       clkStable,
  input  logic       hostCmdValid,
  input  logic [2:0] hostCmd,
  output logic       cke,
  output logic [2:0] memCmd,
  output logic       cmdBusy,
  output logic       ready
);
  localparam int NOP_CYC = (XSNR_CYC > DLL_CYC) ? XSNR_CYC : DLL_CYC;

  srStrobe_t stb;
  logic      cntDone;

  sref_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .exitReq(exitReq),
    .clkStable(clkStable), .cntDone(cntDone), .stb(stb)
  );

  sref_dp #(.NOP_CYC(NOP_CYC)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostCmdValid(hostCmdValid),
    .hostCmd(hostCmd), .cntDone(cntDone), .cke(cke), .memCmd(memCmd),
    .cmdBusy(cmdBusy), .ready(ready)
  );
endmodule

// File: rtl/sref_sequencer_chk.sv
module sref_sequencer_chk #(
  parameter int NOP_CYC = 200
) (
  input logic       clk,
  input logic       rstN,
  input logic       cke,
  input logic [2:0] memCmd,
  input logic       cmdBusy,
  input logic       ready,
  input logic       clkStable
);
  localparam int RW = $clog2(NOP_CYC + 2);
  localparam logic [RW-1:0] SAT = RW'(NOP_CYC + 1);

  logic [RW-1:0] wakeRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               wakeRun <= '0;
    else if (!cke || ready)  wakeRun <= '0;
    else if (wakeRun != SAT) wakeRun <= wakeRun + 1'b1;
  end

  AST_REF_WITH_CKE_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (memCmd == 3'b001) |-> (!cke && $past(cke))); // R3
  AST_CKE_RISE_AFTER_CLK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> $past(clkStable)); // R5
  AST_LOW_CKE_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> !ready); // R4
  AST_WAKE_NOP_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (cke && !ready) |-> (memCmd == 3'b111)); // R6
  AST_READY_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> (wakeRun == RW'(NOP_CYC))); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    cmdBusy |-> !ready); // R7
endmodule

bind sref_sequencer sref_sequencer_chk #(.NOP_CYC(NOP_CYC)) uChk (
  .clk(clk), .rstN(rstN), .cke(cke), .memCmd(memCmd), .cmdBusy(cmdBusy),
  .ready(ready), .clkStable(clkStable)
);

// File: tb/sref_sequencer_test.sv
module sref_sequencer_test;
  localparam int XSNR = 20;
  localparam int DLL  = 200;
  localparam int EXP_WIN = (XSNR > DLL) ? XSNR : DLL;
  localparam logic [2:0] NOP = 3'b111;
  localparam logic [2:0] REF = 3'b001;
  localparam logic [2:0] RD  = 3'b101;

  // {valid, cmd, expCmd, expBusy}
  localparam int NV = 6;
  localparam logic [7:0] VEC [NV] = '{
    {1'b1, 3'b101, 3'b101, 1'b0},
    {1'b1, 3'b100, 3'b100, 1'b0},
    {1'b0, 3'b011, 3'b111, 1'b0},
    {1'b1, 3'b011, 3'b011, 1'b0},
    {1'b1, 3'b010, 3'b010, 1'b0},
    {1'b0, 3'b000, 3'b111, 1'b0}
  };

  logic clk = 0, rstN = 0;
  logic enterReq = 0, exitReq = 0, clkStable = 0, hostCmdValid = 0;
  logic [2:0] hostCmd = NOP;
  logic cke, cmdBusy, ready;
  logic [2:0] memCmd;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sref_sequencer #(.XSNR_CYC(XSNR), .DLL_CYC(DLL)) uut (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .exitReq(exitReq),
    .clkStable(clkStable), .hostCmdValid(hostCmdValid), .hostCmd(hostCmd),
    .cke(cke), .memCmd(memCmd), .cmdBusy(cmdBusy), .ready(ready)
  );

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  endtask

  task automatic enterSr();
    enterReq = 1;
    tick();
    enterReq = 0;
    #1;
    chk("R3 cke low on entry", cke, 0);
    chk("R3 refresh on entry", memCmd, REF);
    tick();
    #1;
    chk("R3 single refresh", memCmd, NOP);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    #1;
    chk("R1 cke", cke, 1);
    chk("R1 ready", ready, 1);
    chk("R1 busy", cmdBusy, 0);
    chk("R1 cmd", memCmd, NOP);

    // R2 forwarding table
    for (int i = 0; i < NV; i++) begin
      hostCmdValid = VEC[i][7];
      hostCmd = VEC[i][6:4];
      #1;
      chk("R2 fwd cmd", memCmd, VEC[i][3:1]);
      chk("R2 busy", cmdBusy, VEC[i][0]);
      tick();
    end
    hostCmdValid = 0;

    // R8 exit while idle
    exitReq = 1; tick(); exitReq = 0; tick(); #1;
    chk("R8 exit ignored cke", cke, 1);
    chk("R8 exit ignored ready", ready, 1);

    enterSr();
    // R4/R7/R8 in self-refresh
    hostCmdValid = 1; hostCmd = RD; enterReq = 1;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk("R4 cke held low", cke, 0);
      chk("R7 no forward", memCmd, NOP);
      chk("R7 busy", cmdBusy, 1);
      tick();
    end
    enterReq = 0;
    chk("R8 enter ignored in sr", cke, 0);

    // R5 exit waits for clock
    exitReq = 1; tick(); exitReq = 0;
    for (int i = 0; i < 5; i++) begin
      #1; chk("R5 cke low awaiting clk", cke, 0); tick();
    end
    clkStable = 1; #1;
    chk("R5 cke low same cycle", cke, 0);
    tick(); #1;
    chk("R5 cke rises", cke, 1);

    // R6 window
    begin
      int cnt = 0;
      while (!ready && cnt < EXP_WIN + 10) begin
        if (memCmd != NOP) chk("R6 nop only", memCmd, NOP);
        if (cmdBusy != 1) chk("R7 busy in window", cmdBusy, 1);
        cnt++;
        tick(); #1;
      end
      chk("R6 window length", cnt, EXP_WIN);
    end
    chk("R9 forward after wake", memCmd, RD);
    chk("R9 busy cleared", cmdBusy, 0);
    hostCmdValid = 0;
    tick(); tick();

    // R9 second entry, clock already stable
    enterSr();
    exitReq = 1; tick(); exitReq = 0; #1;
    chk("R5 cke low in wait", cke, 0);
    tick(); #1;
    chk("R5 cke rises second", cke, 1);
    repeat (EXP_WIN - 1) tick();
    #1; chk("R6 not ready one early", ready, 0);
    tick(); #1;
    chk("R6 ready on time", ready, 1);
    chk("R9 cke high", cke, 1);
    finishRun();
  end
endmodule